// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block guards one shared memory region for several requesters that use load-exclusive and store-exclusive pairs to build atomic read-modify-write sequences. Each requester owns a request port, and its port index is its transaction ID. A request carries a valid flag, a write flag, an exclusive flag, a clear-reservation flag, an address and a transfer size. The monitor accepts one request per cycle. When several ports request in the same cycle, the lowest ID goes first. One cycle after each grant it returns a response code and drives the memory read enable or the gated memory write enable.

The monitor holds a single reservation, and the most recent exclusive read always replaces it. The reservation records the requester ID, the address tag (the address bits from the parameter `TAG_LSB` up to the top) and the transfer size. An exclusive write succeeds only when all three match a live reservation. A successful exclusive write reaches memory and is answered with a distinct success code. A failed exclusive write is suppressed and answered with the ordinary code. A plain write from another requester to the reserved granule cancels the reservation, as does a clear-reservation request.

Top module: `excl_monitor`

## Requirements
- R1: Addresses are compared only on the tag `addr[ADDR_W-1:TAG_LSB]`, where `TAG_LSB` is between 3 and 11. An exclusive write anywhere in the reserved granule can succeed. An exclusive write to another granule fails.
- R2: An exclusive read (`req_excl=1`, `req_write=0`) records its ID, tag and size. A following exclusive write from that ID, with the same tag and size, drives `mem_we=1` and is answered with code 2'b01 (success).
- R3: Only the latest exclusive read holds the reservation. After requester A and then requester B make exclusive reads, an exclusive write from A fails and one from B succeeds.
- R4: A failed exclusive write drives `mem_we=0` and is answered with code 2'b00.
- R5: Plain reads and writes are always answered with 2'b00. A plain read drives `mem_re=1`. A plain write drives `mem_we=1`.
- R6: A plain write from a different ID to the reserved granule cancels the reservation. A plain write from the reserving ID does not cancel it.
- R7: An exclusive write fails when its size differs from the size of the reserving read. Size codes: 0 = byte, 1 = half, 2 = word, 3 = double.
- R8: A request with `req_clrex=1` (highest-precedence field) cancels the reservation. It is answered with 2'b00 and drives neither `mem_we` nor `mem_re`.
- R9: Plain reads from any ID leave the reservation unchanged.
- R10: Any exclusive write from the reserving ID cancels the reservation, whether it succeeds or fails.
- R11: `req_ready` is one-hot or zero. It goes to the lowest-numbered valid port. A requester holds its request until it sees `req_ready`.
- R12: After reset, no reservation exists and `resp_valid=0`. Reset is asynchronous and active-low, and its release passes through two flops.
- R13: `resp_valid`, `resp_id`, `resp_code`, `mem_we`, `mem_re`, `mem_addr` and `mem_size` are registered and appear one cycle after the grant. When `resp_valid=0`, both memory enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Request present, one bit per ID |
| req_write | input | N_REQ | 1 = write, 0 = read |
| req_excl | input | N_REQ | Exclusive flag |
| req_clrex | input | N_REQ | Clear-reservation request |
| req_addr | input | N_REQ*ADDR_W | Byte addresses, ID i in slice i |
| req_size | input | N_REQ*SIZE_W | Transfer size codes, ID i in slice i |
| req_ready | output | N_REQ | Grant, one-hot or zero |
| resp_valid | output | 1 | Response present |
| resp_id | output | ID_W | ID of the answered request |
| resp_code | output | 2 | 2'b00 ordinary, 2'b01 exclusive success |
| mem_we | output | 1 | Gated memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_size | output | SIZE_W | Memory transfer size |

## Verification
The assertions check the following on every cycle:
- The grant is one-hot and goes to the lowest valid port.
- An exclusive read installs its requester as the owner.
- Clear requests, and exclusive writes from the owner, leave the monitor open.
- Plain reads leave the reservation untouched.
- A success code never appears without a memory write.

Some properties depend on a history of several requests and can only be shown by the bench scenarios. These are the last-wins handover between requesters, cancellation by a foreign write to the same granule, size mismatch, granule-boundary tag matching and the grant order under simultaneous requests. The bench's reference model also checks every response against the cycle it is due in.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01
  } resp_e;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_XRD  = 3'd3,
    OP_XWR  = 3'd4,
    OP_CLR  = 3'd5
  } op_e;

  function automatic op_e decode_op(input logic vld, input logic wr,
                                    input logic ex, input logic clr);
    op_e op;
    if (!vld)         op = OP_IDLE;
    else if (clr)     op = OP_CLR;
    else if (ex &&  wr) op = OP_XWR;
    else if (ex && !wr) op = OP_XRD;
    else if (wr)      op = OP_WR;
    else              op = OP_RD;
    return op;
  endfunction

endpackage

// File: rtl/excl_mon_arb.sv
module excl_mon_arb #(
  parameter int N_REQ = 4,
  parameter int ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] valid,
  output logic [N_REQ-1:0] grant,
  output logic             gnt_any,
  output logic [ID_W-1:0]  gnt_id
);

  for (genvar i = 0; i < N_REQ; i++) begin : g_pri
    if (i == 0) begin : g_first
      assign grant[i] = valid[i];
    end else begin : g_rest
      assign grant[i] = valid[i] & ~(|valid[i-1:0]);
    end
  end

  assign gnt_any = |valid;

  always_comb begin
    gnt_id = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (grant[i]) gnt_id = ID_W'(i);
    end
  end

  // R11: at most one grant per cycle
  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R11: a grant only goes to a requesting port, and a request never starves the cycle
  assert_grant_subset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~valid) == '0) && ((|valid) == (|grant)));

endmodule

// File: rtl/excl_mon_rsv.sv
module excl_mon_rsv
  import excl_mon_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int TAG_W  = 26,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [ID_W-1:0]   id,
  input  logic [TAG_W-1:0]  tag,
  input  logic [SIZE_W-1:0] size,
  output logic              xwr_pass
);

  logic              rsv_valid, rsv_valid_nxt;
  logic [ID_W-1:0]   rsv_id,    rsv_id_nxt;
  logic [TAG_W-1:0]  rsv_tag,   rsv_tag_nxt;
  logic [SIZE_W-1:0] rsv_size,  rsv_size_nxt;
  logic              upd_en;
  logic              id_hit, tag_hit, size_hit;

  assign id_hit   = rsv_valid && (id == rsv_id);
  assign tag_hit  = (tag == rsv_tag);
  assign size_hit = (size == rsv_size);
  assign upd_en   = (op != OP_IDLE);

  always_comb begin
    rsv_valid_nxt = rsv_valid;
    rsv_id_nxt    = rsv_id;
    rsv_tag_nxt   = rsv_tag;
    rsv_size_nxt  = rsv_size;
    xwr_pass      = 1'b0;
    unique case (op)
      OP_XRD: begin
        rsv_valid_nxt = 1'b1;
        rsv_id_nxt    = id;
        rsv_tag_nxt   = tag;
        rsv_size_nxt  = size;
      end
      OP_XWR: begin
        xwr_pass = id_hit && tag_hit && size_hit;
        if (id_hit) rsv_valid_nxt = 1'b0;
      end
      OP_WR: begin
        if (rsv_valid && (id != rsv_id) && tag_hit) rsv_valid_nxt = 1'b0;
      end
      OP_CLR: begin
        rsv_valid_nxt = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_valid <= 1'b0;
      rsv_id    <= '0;
      rsv_tag   <= '0;
      rsv_size  <= '0;
    end else if (upd_en) begin
      rsv_valid <= rsv_valid_nxt;
      rsv_id    <= rsv_id_nxt;
      rsv_tag   <= rsv_tag_nxt;
      rsv_size  <= rsv_size_nxt;
    end
  end

  // R2: an exclusive read installs its requester as owner
  assert_xrd_installs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XRD) |=> (rsv_valid && rsv_id == $past(id) && rsv_size == $past(size)));

  // R8: clear request always opens the monitor
  assert_clear_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |=> !rsv_valid);

  // R9: plain reads leave the reservation untouched
  assert_read_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD) |=> ($stable(rsv_valid) && $stable(rsv_id) && $stable(rsv_tag)
                       && $stable(rsv_size)));

  // R10: owner's exclusive write leaves the monitor open
  assert_owner_xwr_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XWR && rsv_valid && id == rsv_id) |=> !rsv_valid);

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int N_REQ   = 4,
  parameter int ADDR_W  = 32,
  parameter int TAG_LSB = 6,
  parameter int SIZE_W  = 2,
  localparam int ID_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         req_valid,
  input  logic [N_REQ-1:0]         req_write,
  input  logic [N_REQ-1:0]         req_excl,
  input  logic [N_REQ-1:0]         req_clrex,
  input  logic [N_REQ*ADDR_W-1:0]  req_addr,
  input  logic [N_REQ*SIZE_W-1:0]  req_size,
  output logic [N_REQ-1:0]         req_ready,
  output logic                     resp_valid,
  output logic [ID_W-1:0]          resp_id,
  output logic [1:0]               resp_code,
  output logic                     mem_we,
  output logic                     mem_re,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [SIZE_W-1:0]        mem_size
);

  localparam int TAG_W = ADDR_W - TAG_LSB;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // arbitration
  logic [N_REQ-1:0] grant;
  logic             gnt_any;
  logic [ID_W-1:0]  gnt_id;

  excl_mon_arb #(.N_REQ(N_REQ), .ID_W(ID_W)) i_arb (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .valid  (req_valid),
    .grant  (grant),
    .gnt_any(gnt_any),
    .gnt_id (gnt_id)
  );

  assign req_ready = grant;

  // select granted request fields
  logic              sel_write, sel_excl, sel_clr;
  logic [ADDR_W-1:0] sel_addr;
  logic [SIZE_W-1:0] sel_size;
  op_e               sel_op;

  always_comb begin
    sel_write = 1'b0;
    sel_excl  = 1'b0;
    sel_clr   = 1'b0;
    sel_addr  = '0;
    sel_size  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (grant[i]) begin
        sel_write = req_write[i];
        sel_excl  = req_excl[i];
        sel_clr   = req_clrex[i];
        sel_addr  = req_addr[i*ADDR_W +: ADDR_W];
        sel_size  = req_size[i*SIZE_W +: SIZE_W];
      end
    end
  end

  assign sel_op = decode_op(gnt_any, sel_write, sel_excl, sel_clr);

  logic [TAG_W-1:0] sel_tag;
  logic             xwr_pass;

  assign sel_tag = sel_addr[ADDR_W-1:TAG_LSB];

  excl_mon_rsv #(.ID_W(ID_W), .TAG_W(TAG_W), .SIZE_W(SIZE_W)) i_rsv (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .op      (sel_op),
    .id      (gnt_id),
    .tag     (sel_tag),
    .size    (sel_size),
    .xwr_pass(xwr_pass)
  );

  // response and memory-side next state
  logic              resp_valid_nxt, mem_we_nxt, mem_re_nxt;
  logic [1:0]        resp_code_nxt;

  always_comb begin
    resp_valid_nxt = gnt_any;
    resp_code_nxt  = RESP_OKAY;
    mem_we_nxt     = 1'b0;
    mem_re_nxt     = 1'b0;
    unique case (sel_op)
      OP_RD, OP_XRD: mem_re_nxt = 1'b1;
      OP_WR:         mem_we_nxt = 1'b1;
      OP_XWR: begin
        mem_we_nxt = xwr_pass;
        if (xwr_pass) resp_code_nxt = RESP_EXOKAY;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      resp_valid <= 1'b0;
      resp_code  <= RESP_OKAY;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
    end else begin
      resp_valid <= resp_valid_nxt;
      resp_code  <= resp_code_nxt;
      mem_we     <= mem_we_nxt;
      mem_re     <= mem_re_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      resp_id  <= '0;
      mem_addr <= '0;
      mem_size <= '0;
    end else if (gnt_any) begin
      resp_id  <= gnt_id;
      mem_addr <= sel_addr;
      mem_size <= sel_size;
    end
  end

  // R2/R4: success code only travels with a memory write
  assert_exokay_writes_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (resp_valid && resp_code == RESP_EXOKAY) |-> (mem_we && !mem_re));

  // R13: no memory activity without a response
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_core_n)
    !resp_valid |-> (!mem_we && !mem_re));

  // R13: a grant is answered in the following cycle with its ID
  assert_resp_follows_R13: assert property (@(posedge clk) disable iff (!rst_core_n)
    gnt_any |=> (resp_valid && resp_id == $past(gnt_id)));

endmodule

// File: tb/test_excl_monitor.sv
module test_excl_monitor;

  localparam int N   = 4;
  localparam int AW  = 32;
  localparam int TL  = 6;
  localparam int SW  = 2;
  localparam int IW  = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_valid, req_write, req_excl, req_clrex;
  logic [N*AW-1:0] req_addr;
  logic [N*SW-1:0] req_size;
  logic [N-1:0]    req_ready;
  logic            resp_valid, mem_we, mem_re;
  logic [IW-1:0]   resp_id;
  logic [1:0]      resp_code;
  logic [AW-1:0]   mem_addr;
  logic [SW-1:0]   mem_size;

  always #5 clk = ~clk;

  excl_monitor #(.N_REQ(N), .ADDR_W(AW), .TAG_LSB(TL), .SIZE_W(SW)) i_excl_monitor (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_excl(req_excl),
    .req_clrex(req_clrex), .req_addr(req_addr), .req_size(req_size),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_id(resp_id),
    .resp_code(resp_code), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_size(mem_size)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // pending requests
  bit          p_v[N], p_w[N], p_x[N], p_c[N];
  logic [31:0] p_a[N];
  logic [1:0]  p_s[N];

  // reference reservation
  bit          m_v;
  int          m_id;
  logic [31:0] m_tag;
  logic [1:0]  m_size;

  // expected registered response
  bit          e_valid, e_we, e_re;
  int          e_id;
  logic [1:0]  e_code;
  string       e_req;
  int          last_g = -1;

  logic [1:0]  last_code;
  bit          last_we, last_re;
  int          id_log[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tagof(input logic [31:0] a);
    return a >> TL;
  endfunction

  task automatic tick();
    logic [N-1:0] exp_rdy;
    int g;
    @(negedge clk);
    if (e_valid) begin
      check(resp_valid === 1'b1, "R13", "resp_valid", int'(resp_valid), 1);
      check(int'(resp_id) == e_id, "R13", "resp_id", int'(resp_id), e_id);
      check(resp_code === e_code, e_req, "resp_code", int'(resp_code), int'(e_code));
      check(mem_we === e_we, e_req, "mem_we", int'(mem_we), int'(e_we));
      check(mem_re === e_re, e_req, "mem_re", int'(mem_re), int'(e_re));
      last_code = resp_code; last_we = mem_we; last_re = mem_re;
      id_log.push_back(int'(resp_id));
    end else begin
      check(resp_valid === 1'b0, "R13", "idle resp_valid", int'(resp_valid), 0);
    end
    if (last_g >= 0) p_v[last_g] = 0;
    for (int i = 0; i < N; i++) begin
      req_valid[i] = p_v[i];
      req_write[i] = p_w[i];
      req_excl[i]  = p_x[i];
      req_clrex[i] = p_c[i];
      req_addr[i*AW +: AW] = p_a[i];
      req_size[i*SW +: SW] = p_s[i];
    end
    #1;
    g = -1;
    for (int i = N-1; i >= 0; i--) if (p_v[i]) g = i;
    exp_rdy = '0;
    if (g >= 0) exp_rdy[g] = 1'b1;
    check(req_ready === exp_rdy, "R11", "req_ready", int'(req_ready), int'(exp_rdy));
    last_g = g;
    e_valid = (g >= 0);
    e_we = 0; e_re = 0; e_code = 2'b00; e_req = "R5";
    if (g >= 0) begin
      e_id = g;
      if (p_c[g]) begin
        m_v = 0; e_req = "R8";
      end else if (p_x[g] && !p_w[g]) begin
        m_v = 1; m_id = g; m_tag = tagof(p_a[g]); m_size = p_s[g];
        e_re = 1; e_req = "R2";
      end else if (p_x[g] && p_w[g]) begin
        if (m_v && m_id == g && m_tag == tagof(p_a[g]) && m_size == p_s[g]) begin
          e_we = 1; e_code = 2'b01; e_req = "R2";
        end else e_req = "R4";
        if (m_v && m_id == g) m_v = 0;
      end else if (p_w[g]) begin
        e_we = 1;
        if (m_v && m_id != g && m_tag == tagof(p_a[g])) m_v = 0;
      end else begin
        e_re = 1; e_req = "R9";
      end
    end
  endtask

  task automatic post(input int id, input bit w, input bit x, input bit c,
                      input logic [31:0] a, input logic [1:0] s);
    p_v[id] = 1; p_w[id] = w; p_x[id] = x; p_c[id] = c; p_a[id] = a; p_s[id] = s;
  endtask

  task automatic drain();
    bit busy;
    do begin
      tick();
      busy = e_valid;
      for (int i = 0; i < N; i++) if (p_v[i]) busy = 1;
    end while (busy);
    tick();
  endtask

  task automatic op(input int id, input bit w, input bit x, input bit c,
                    input logic [31:0] a, input logic [1:0] s);
    post(id, w, x, c, a, s);
    drain();
  endtask

  task automatic expect_last(input logic [1:0] code, input bit we, input string req);
    check(last_code === code, req, "scenario code", int'(last_code), int'(code));
    check(last_we === we, req, "scenario mem_we", int'(last_we), int'(we));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_write = '0; req_excl = '0; req_clrex = '0;
    req_addr = '0; req_size = '0;
    for (int i = 0; i < N; i++) begin
      p_v[i] = 0; p_w[i] = 0; p_x[i] = 0; p_c[i] = 0; p_a[i] = '0; p_s[i] = '0;
    end
    m_v = 0; m_id = 0; m_tag = '0; m_size = '0;
    e_valid = 0; e_we = 0; e_re = 0; e_id = 0; e_code = 2'b00; e_req = "R5";
    last_code = 2'b00; last_we = 0; last_re = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(resp_valid === 1'b0, "R12", "resp_valid in reset", int'(resp_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(resp_valid === 1'b0 && mem_we === 1'b0, "R12", "after reset quiet",
          int'(resp_valid), 0);

    // R12: no reservation after reset
    op(0, 1, 1, 0, 32'h100, 2'd2);  expect_last(2'b00, 0, "R12");
    // R2: matching pair succeeds
    op(1, 0, 1, 0, 32'h200, 2'd2);
    op(1, 1, 1, 0, 32'h200, 2'd2);  expect_last(2'b01, 1, "R2");
    // R1: same granule succeeds, next granule fails
    op(2, 0, 1, 0, 32'h300, 2'd2);
    op(2, 1, 1, 0, 32'h33C, 2'd2);  expect_last(2'b01, 1, "R1");
    op(2, 0, 1, 0, 32'h300, 2'd2);
    op(2, 1, 1, 0, 32'h340, 2'd2);  expect_last(2'b00, 0, "R1");
    // R3: last exclusive read wins
    op(0, 0, 1, 0, 32'h400, 2'd2);
    op(1, 0, 1, 0, 32'h400, 2'd2);
    op(0, 1, 1, 0, 32'h400, 2'd2);  expect_last(2'b00, 0, "R3");
    op(1, 1, 1, 0, 32'h400, 2'd2);  expect_last(2'b01, 1, "R3");
    // R6: foreign write cancels, own write keeps
    op(3, 0, 1, 0, 32'h500, 2'd2);
    op(1, 1, 0, 0, 32'h508, 2'd2);  expect_last(2'b00, 1, "R6");
    op(3, 1, 1, 0, 32'h500, 2'd2);  expect_last(2'b00, 0, "R6");
    op(3, 0, 1, 0, 32'h500, 2'd2);
    op(3, 1, 0, 0, 32'h500, 2'd2);
    op(3, 1, 1, 0, 32'h500, 2'd2);  expect_last(2'b01, 1, "R6");
    // R7: byte read then word write fails
    op(0, 0, 1, 0, 32'h600, 2'd0);
    op(0, 1, 1, 0, 32'h600, 2'd2);  expect_last(2'b00, 0, "R7");
    // R8: clear opens, no memory access
    op(2, 0, 1, 0, 32'h700, 2'd2);
    op(2, 0, 0, 1, 32'h700, 2'd2);  expect_last(2'b00, 0, "R8");
    check(last_re === 1'b0, "R8", "clear mem_re", int'(last_re), 0);
    op(2, 1, 1, 0, 32'h700, 2'd2);  expect_last(2'b00, 0, "R8");
    // R9: plain reads do not disturb
    op(1, 0, 1, 0, 32'h800, 2'd1);
    op(0, 0, 0, 0, 32'h800, 2'd1);
    op(2, 0, 0, 0, 32'h800, 2'd1);
    op(1, 1, 1, 0, 32'h800, 2'd1);  expect_last(2'b01, 1, "R9");
    // R10: owner's exclusive write opens the monitor
    op(0, 0, 1, 0, 32'h900, 2'd3);
    op(0, 1, 1, 0, 32'h900, 2'd3);  expect_last(2'b01, 1, "R10");
    op(0, 1, 1, 0, 32'h900, 2'd3);  expect_last(2'b00, 0, "R10");
    op(0, 0, 1, 0, 32'h900, 2'd3);
    op(0, 1, 1, 0, 32'h940, 2'd3);
    op(0, 1, 1, 0, 32'h900, 2'd3);  expect_last(2'b00, 0, "R10");
    // R5: plain accesses
    op(3, 0, 0, 0, 32'hA00, 2'd2);  expect_last(2'b00, 0, "R5");
    check(last_re === 1'b1, "R5", "plain read mem_re", int'(last_re), 1);
    op(3, 1, 0, 0, 32'hA00, 2'd2);  expect_last(2'b00, 1, "R5");
    // R11: simultaneous requests served lowest ID first
    id_log.delete();
    for (int i = N-1; i >= 0; i--) post(i, 0, 0, 0, 32'hC00, 2'd2);
    drain();
    check(id_log.size() == N, "R11", "grant count", id_log.size(), N);
    for (int i = 0; i < N && i < id_log.size(); i++)
      check(id_log[i] == i, "R11", "grant order", id_log[i], i);
    // R11/R3: simultaneous exclusive reads, higher ID is served last and wins
    post(3, 0, 1, 0, 32'hB00, 2'd2);
    post(1, 0, 1, 0, 32'hB00, 2'd2);
    drain();
    op(1, 1, 1, 0, 32'hB00, 2'd2);  expect_last(2'b00, 0, "R11");
    op(3, 0, 1, 0, 32'hB00, 2'd2);
    op(3, 1, 1, 0, 32'hB00, 2'd2);  expect_last(2'b01, 1, "R11");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule